// File: doc/BRIEF.md
# Adaptive Viterbi Survivor Pruning Unit

This block applies the adaptive pruning rule of a Viterbi decoder to one trellis time step. The surrounding decoder starts a step by presenting the previous step's lowest survivor cost, a starting threshold and a survivor limit. It then streams the candidate paths. Each candidate carries a slot index, its parent path metric and the branch cost of its extension. The block forms each candidate metric, stores it in a local slot buffer, and marks as kept every candidate whose metric lies under the lowest previous cost plus the threshold.

When more candidates pass than the limit allows, the threshold is cut by two and the compare-and-count pass runs again over the buffered metrics. The input is not read again. This bounds the survivor set without sorting the candidates. One slot is compared per clock.

At the end of the step the block gives a one-cycle done pulse. With it come the keep mask, the survivor count, the lowest kept metric (the reference cost for the next step) and the threshold the final pass used. Each new step starts again from its own input threshold. The branch metric units and the survivor path memory lie outside this block.

Top module: `avs_prune`

## Requirements
- R1: A candidate's metric is its parent metric plus its branch cost, formed MW+1 bits wide so that the sum never wraps (255 + 255 = 510 at MW = 8).
- R2: With a threshold T above zero, a loaded candidate is kept exactly when its metric is strictly less than the reference cost plus T.
- R3: With T equal to zero, a loaded candidate is kept exactly when its metric is less than or equal to the reference cost, so metrics equal to the reference survive.
- R4: While the survivor count exceeds the limit and T is above zero, T is lowered by 2 (to 0 if it is 1) and the pass repeats. The final count is at or below the limit unless the final T is 0.
- R5: The done output is high for exactly one cycle per step. Bit i of the keep mask belongs to slot index i, and the survivor count equals the number of set mask bits.
- R6: The new reference cost is the lowest metric among kept candidates. It is all ones (511 at MW = 8) when nothing is kept.
- R7: The reported threshold is the one used in the final pass. Every step starts from the threshold given with its own start, whatever earlier steps did.
- R8: Slots not written during a step are never kept. A slot written twice in one step uses the later candidate.
- R9: A start pulse is ignored while a step is in progress. Candidate strobes are ignored except between a start and the candidate marked last.
- R10: After reset, done is low, the keep mask, count and threshold outputs are zero, and the reference cost output is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| stepStart | input | 1 | Begins a step and captures the three settings below |
| refCost | input | MW+1 | Lowest survivor cost of the previous step |
| thrStart | input | TW | Starting threshold for this step |
| survLimit | input | CW | Maximum survivor count |
| candValid | input | 1 | Candidate strobe |
| candSlot | input | IDXW | Slot index of the candidate |
| candParent | input | MW | Parent path metric |
| candBranch | input | MW | Branch cost of the extension |
| candLast | input | 1 | Marks the final candidate of the step |
| doneValid | output | 1 | One-cycle result strobe |
| keepMask | output | NCAND | Kept flag per slot |
| keepCount | output | CW | Number of kept candidates |
| newRefCost | output | MW+1 | Lowest kept metric |
| thrUsed | output | TW | Threshold of the final pass |

## Verification
The hardest state to reach from the ports is a chain of several threshold cuts that ends with T at zero and the count still above the limit. This needs many candidates packed just under the reference cost, with ties exactly at it. The bench reaches it by sweeping small limits against wide and narrow thresholds over clustered metric sets. It also runs a directed step with odd T, tied metrics and a zero limit. A brute-force reference recomputes every pass in the bench and compares the mask, count, minimum and final threshold.

// File: rtl/avs_pkg.sv
package avs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_SCAN = 3'd2,
    ST_EVAL = 3'd3
  } avsState_t;

  typedef struct packed {
    logic cfgLoad;
    logic slotWrite;
    logic passClr;
    logic cmpEn;
    logic thrCut;
    logic finish;
  } avsStrb_t;
endpackage

// File: rtl/avs_ctrl.sv
module avs_ctrl
  import avs_pkg::*;
#(
  parameter int NCAND = 16,
  localparam int IDXW = (NCAND > 1) ? $clog2(NCAND) : 1
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            stepStart,
  input  logic            candValid,
  input  logic            candLast,
  input  logic            overLimit,
  input  logic            thrZero,
  output avsStrb_t        strb,
  output logic [IDXW-1:0] scanIdx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NCAND - 1);

  avsState_t state, stateNxt;
  logic [IDXW-1:0] scanNxt;

  always_comb begin
    stateNxt = state;
    scanNxt  = scanIdx;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (stepStart) begin
          strb.cfgLoad = 1'b1;
          stateNxt     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.slotWrite = 1'b1;
        if (candValid && candLast) begin
          strb.passClr = 1'b1;
          scanNxt      = '0;
          stateNxt     = ST_SCAN;
        end
      end
      ST_SCAN: begin
        strb.cmpEn = 1'b1;
        if (scanIdx == LAST_IDX) begin
          stateNxt = ST_EVAL;
        end else begin
          scanNxt = scanIdx + 1'b1;
        end
      end
      ST_EVAL: begin
        if (overLimit && !thrZero) begin
          strb.thrCut  = 1'b1;
          strb.passClr = 1'b1;
          scanNxt      = '0;
          stateNxt     = ST_SCAN;
        end else begin
          strb.finish = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      state   <= stateNxt;
      scanIdx <= scanNxt;
    end
  end

  AST_CUT_RESCANS: assert property (@(posedge clk) disable iff (!rstN)
    strb.thrCut |=> (state == ST_SCAN && scanIdx == '0)) else $error("cut without rescan"); // R4
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN && stepStart) |=> (state == ST_SCAN || state == ST_EVAL)) else $error("start disturbed scan"); // R9
endmodule

// File: rtl/avs_datapath.sv
module avs_datapath
  import avs_pkg::*;
#(
  parameter int NCAND = 16,
  parameter int MW    = 8,
  parameter int TW    = 6,
  localparam int IDXW = (NCAND > 1) ? $clog2(NCAND) : 1,
  localparam int CW   = $clog2(NCAND + 1),
  localparam int SW   = MW + 1,
  localparam int LW   = MW + 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  avsStrb_t         strb,
  input  logic [IDXW-1:0]  scanIdx,
  input  logic [SW-1:0]    refCost,
  input  logic [TW-1:0]    thrStart,
  input  logic [CW-1:0]    survLimit,
  input  logic             candValid,
  input  logic [IDXW-1:0]  candSlot,
  input  logic [MW-1:0]    candParent,
  input  logic [MW-1:0]    candBranch,
  output logic             overLimit,
  output logic             thrZero,
  output logic             doneValid,
  output logic [NCAND-1:0] keepMask,
  output logic [CW-1:0]    keepCount,
  output logic [SW-1:0]    newRefCost,
  output logic [TW-1:0]    thrUsed
);
  localparam logic [SW-1:0] MAX_COST = '1;

  logic [SW-1:0]    slotMetric [NCAND];
  logic [NCAND-1:0] slotValid;
  logic [SW-1:0]    refR;
  logic [TW-1:0]    thrR, thrStartR;
  logic [CW-1:0]    limitR;
  logic [NCAND-1:0] keepR;
  logic [CW-1:0]    countR;
  logic [SW-1:0]    minR;

  logic [SW-1:0] candSum;
  logic [SW-1:0] curMetric;
  logic [LW-1:0] bound;
  logic          keptNow;

  assign candSum   = {1'b0, candParent} + {1'b0, candBranch};
  assign curMetric = slotMetric[scanIdx];
  assign bound     = {1'b0, refR} + LW'(thrR);
  assign keptNow   = slotValid[scanIdx] &&
                     ((thrR == '0) ? (curMetric <= refR) : ({1'b0, curMetric} < bound));
  assign overLimit = countR > limitR;
  assign thrZero   = thrR == '0;

  // settings captured at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      refR      <= '0;
      thrStartR <= '0;
      limitR    <= '0;
    end else if (strb.cfgLoad) begin
      refR      <= refCost;
      thrStartR <= thrStart;
      limitR    <= survLimit;
    end
  end

  // working threshold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrR <= '0;
    end else if (strb.cfgLoad) begin
      thrR <= thrStart;
    end else if (strb.thrCut) begin
      thrR <= (thrR >= TW'(2)) ? thrR - TW'(2) : '0;
    end
  end

  // candidate buffer and per-slot keep flags
  for (genvar g = 0; g < NCAND; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotValid[g]  <= 1'b0;
        slotMetric[g] <= '0;
      end else if (strb.cfgLoad) begin
        slotValid[g] <= 1'b0;
      end else if (strb.slotWrite && candValid && candSlot == IDXW'(g)) begin
        slotValid[g]  <= 1'b1;
        slotMetric[g] <= candSum;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        keepR[g] <= 1'b0;
      end else if (strb.passClr) begin
        keepR[g] <= 1'b0;
      end else if (strb.cmpEn && scanIdx == IDXW'(g)) begin
        keepR[g] <= keptNow;
      end
    end
  end

  // survivor count and lowest kept metric
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countR <= '0;
      minR   <= MAX_COST;
    end else if (strb.passClr) begin
      countR <= '0;
      minR   <= MAX_COST;
    end else if (strb.cmpEn && keptNow) begin
      countR <= countR + 1'b1;
      if (curMetric < minR) minR <= curMetric;
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      keepMask   <= '0;
      keepCount  <= '0;
      newRefCost <= MAX_COST;
      thrUsed    <= '0;
    end else begin
      doneValid <= strb.finish;
      if (strb.finish) begin
        keepMask   <= keepR;
        keepCount  <= countR;
        newRefCost <= minR;
        thrUsed    <= thrR;
      end
    end
  end

  AST_NO_EXCESS_SURVIVORS: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (keepCount <= limitR || thrUsed == '0)) else $error("limit exceeded"); // R4
  AST_COUNT_IS_POPCOUNT: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> ($countones(keepMask) == int'(keepCount))) else $error("count mismatch"); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid) else $error("done longer than one cycle"); // R5
  AST_THR_NOT_ABOVE_START: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (thrUsed <= thrStartR)) else $error("threshold grew"); // R7
  AST_EMPTY_MIN: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && keepCount == '0) |-> (newRefCost == MAX_COST)) else $error("min with no survivor"); // R6
  AST_UNLOADED_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmpEn && !slotValid[scanIdx]) |=> !keepR[$past(scanIdx)]) else $error("empty slot kept"); // R8
endmodule

// File: rtl/avs_prune.sv
module avs_prune
  import avs_pkg::*;
#(
  parameter int NCAND = 16,
  parameter int MW    = 8,
  parameter int TW    = 6,
  localparam int IDXW = (NCAND > 1) ? $clog2(NCAND) : 1,
  localparam int CW   = $clog2(NCAND + 1)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepStart,
  input  logic [MW:0]      refCost,
  input  logic [TW-1:0]    thrStart,
  input  logic [CW-1:0]    survLimit,
  input  logic             candValid,
  input  logic [IDXW-1:0]  candSlot,
  input  logic [MW-1:0]    candParent,
  input  logic [MW-1:0]    candBranch,
  input  logic             candLast,
  output logic             doneValid,
  output logic [NCAND-1:0] keepMask,
  output logic [CW-1:0]    keepCount,
  output logic [MW:0]      newRefCost,
  output logic [TW-1:0]    thrUsed
);
  avsStrb_t        strb;
  logic [IDXW-1:0] scanIdx;
  logic            overLimit;
  logic            thrZero;

  avs_ctrl #(.NCAND(NCAND)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .stepStart (stepStart),
    .candValid (candValid),
    .candLast  (candLast),
    .overLimit (overLimit),
    .thrZero   (thrZero),
    .strb      (strb),
    .scanIdx   (scanIdx)
  );

  avs_datapath #(.NCAND(NCAND), .MW(MW), .TW(TW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .scanIdx    (scanIdx),
    .refCost    (refCost),
    .thrStart   (thrStart),
    .survLimit  (survLimit),
    .candValid  (candValid),
    .candSlot   (candSlot),
    .candParent (candParent),
    .candBranch (candBranch),
    .overLimit  (overLimit),
    .thrZero    (thrZero),
    .doneValid  (doneValid),
    .keepMask   (keepMask),
    .keepCount  (keepCount),
    .newRefCost (newRefCost),
    .thrUsed    (thrUsed)
  );
endmodule

// File: tb/tb_avs_prune.sv
module tb_avs_prune;
  localparam int NCAND = 16;
  localparam int MW    = 8;
  localparam int TW    = 6;
  localparam int IDXW  = 4;
  localparam int CW    = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             stepStart = 1'b0;
  logic [MW:0]      refCost = '0;
  logic [TW-1:0]    thrStart = '0;
  logic [CW-1:0]    survLimit = '0;
  logic             candValid = 1'b0;
  logic [IDXW-1:0]  candSlot = '0;
  logic [MW-1:0]    candParent = '0;
  logic [MW-1:0]    candBranch = '0;
  logic             candLast = 1'b0;
  logic             doneValid;
  logic [NCAND-1:0] keepMask;
  logic [CW-1:0]    keepCount;
  logic [MW:0]      newRefCost;
  logic [TW-1:0]    thrUsed;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int seed = 12345;

  int refPar [NCAND];
  int refBr  [NCAND];
  bit refVal [NCAND];

  always #2 clk = ~clk;

  avs_prune #(.NCAND(NCAND), .MW(MW), .TW(TW)) dut (
    .clk(clk), .rstN(rstN), .stepStart(stepStart), .refCost(refCost),
    .thrStart(thrStart), .survLimit(survLimit), .candValid(candValid),
    .candSlot(candSlot), .candParent(candParent), .candBranch(candBranch),
    .candLast(candLast), .doneValid(doneValid), .keepMask(keepMask),
    .keepCount(keepCount), .newRefCost(newRefCost), .thrUsed(thrUsed)
  );

  function automatic int nextRand(int range);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 32'h7fff) % range;
  endfunction

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic clearRef();
    for (int i = 0; i < NCAND; i++) begin
      refPar[i] = 0; refBr[i] = 0; refVal[i] = 1'b0;
    end
  endtask

  task automatic doStart(input int dmin, input int thr, input int lim);
    refCost = (MW+1)'(dmin); thrStart = TW'(thr); survLimit = CW'(lim);
    stepStart = 1'b1;
    @(negedge clk);
    stepStart = 1'b0;
  endtask

  task automatic sendCand(input int slot, input int p, input int b, input bit last);
    candValid = 1'b1; candSlot = IDXW'(slot);
    candParent = MW'(p); candBranch = MW'(b); candLast = last;
    refPar[slot] = p; refBr[slot] = b; refVal[slot] = 1'b1;
    @(negedge clk);
    candValid = 1'b0; candLast = 1'b0;
  endtask

  task automatic waitDone();
    while (!doneValid) @(negedge clk);
  endtask

  task automatic refCompute(input int dmin, input int thr, input int lim,
                            output int mask, output int cnt, output int mn, output int t);
    t = thr;
    forever begin
      mask = 0; cnt = 0; mn = 511;
      for (int i = 0; i < NCAND; i++) begin
        int met;
        bit k;
        met = refPar[i] + refBr[i];
        k = refVal[i] && ((t == 0) ? (met <= dmin) : (met < dmin + t));
        if (k) begin
          mask |= (1 << i); cnt++;
          if (met < mn) mn = met;
        end
      end
      if (cnt > lim && t > 0) t = (t >= 2) ? t - 2 : 0;
      else break;
    end
  endtask

  task automatic checkStep(input string tag, input int dmin, input int thr, input int lim);
    int eMask, eCnt, eMin, eThr;
    refCompute(dmin, thr, lim, eMask, eCnt, eMin, eThr);
    waitDone();
    check({tag, " mask"}, int'(keepMask), eMask);
    check({tag, " count"}, int'(keepCount), eCnt);
    check({tag, " min"}, int'(newRefCost), eMin);
    check({tag, " thr"}, int'(thrUsed), eThr);
    @(negedge clk);
    check({tag, " done pulse R5"}, int'(doneValid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 done", int'(doneValid), 0);
    check("R10 mask", int'(keepMask), 0);
    check("R10 count", int'(keepCount), 0);
    check("R10 min", int'(newRefCost), 511);
    check("R10 thr", int'(thrUsed), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 wide sum: 510 dropped, 300 kept (bound 255+63=318)
    clearRef();
    doStart(255, 63, 16);
    sendCand(0, 255, 255, 1'b0);
    sendCand(1, 200, 100, 1'b1);
    checkStep("R1", 255, 63, 16);
    check("R1 min is 300", int'(newRefCost), 300);

    // R3 ties at T=0, odd start T cut 3->1->0, limit 0
    clearRef();
    doStart(40, 3, 0);
    sendCand(0, 40, 0, 1'b0);
    sendCand(1, 30, 10, 1'b0);
    sendCand(2, 41, 0, 1'b0);
    sendCand(3, 39, 0, 1'b1);
    checkStep("R3/R4", 40, 3, 0);
    check("R3 kept ties count", int'(keepCount), 3);

    // R7 next step restarts from its own threshold
    clearRef();
    doStart(40, 3, 16);
    sendCand(0, 40, 2, 1'b1);
    checkStep("R7", 40, 3, 16);
    check("R7 thr restored", int'(thrUsed), 3);

    // R6 nothing kept
    clearRef();
    doStart(10, 4, 5);
    sendCand(5, 100, 1, 1'b0);
    sendCand(9, 14, 0, 1'b1);
    checkStep("R6", 10, 4, 5);
    check("R6 empty min", int'(newRefCost), 511);

    // R8 partial load and rewrite of a slot
    clearRef();
    doStart(50, 10, 16);
    sendCand(3, 10, 1, 1'b0);
    sendCand(3, 90, 0, 1'b0);
    sendCand(7, 45, 2, 1'b1);
    checkStep("R8", 50, 10, 16);
    check("R8 rewritten slot dropped", int'(keepMask[3]), 0);

    // R9 start and candidate strobes ignored during scan
    clearRef();
    doStart(30, 8, 16);
    sendCand(0, 20, 5, 1'b0);
    sendCand(1, 33, 2, 1'b1);
    refCost = '0; thrStart = '0; survLimit = '0; stepStart = 1'b1;
    candValid = 1'b1; candSlot = 4'd2; candParent = 8'd0; candBranch = 8'd0;
    @(negedge clk);
    stepStart = 1'b0; candValid = 1'b0;
    checkStep("R9", 30, 8, 16);
    check("R9 stray slot not kept", int'(keepMask[2]), 0);

    // R2/R4/R5/R6/R7 sweep over thresholds, limits and clustered metrics
    for (int ti = 0; ti < 7; ti++) begin
      for (int li = 0; li < 5; li++) begin
        for (int s = 0; s < 3; s++) begin
          int thrTab [7] = '{0, 1, 2, 5, 9, 20, 63};
          int limTab [5] = '{0, 1, 3, 8, 16};
          int dmin, nSend;
          clearRef();
          dmin = 20 + nextRand(30);
          nSend = 1 + nextRand(NCAND);
          doStart(dmin, thrTab[ti], limTab[li]);
          for (int k = 0; k < nSend; k++) begin
            int slot;
            slot = (s == 2) ? nextRand(NCAND) : k;
            sendCand(slot, dmin - 10 + nextRand(20), nextRand(8), k == nSend - 1);
          end
          checkStep("R2/R4/R5/R6/R7 sweep", dmin, thrTab[ti], limTab[li]);
        end
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule